// File: doc/BRIEF.md
# Non-Volatile Row Buffer Address Assembler

This block forms the addressing path of a non-volatile memory device that sits on a low-power DDR command/address bus. The device reads its array through a set of row data buffers. A preactive command delivers the upper array address bits. A following activate delivers the lower bits and names a target buffer. The block joins the two parts into one array address and issues a load request that moves that row into the chosen buffer. A later read names a buffer and a column. The block returns the array row held in that buffer and the byte offset inside it.

The bank-select bits on the bus pick a buffer. They are not part of the array address, so any row can be placed in any buffer. The configured row-buffer size decides which address bits count. In a large row the low activate bits carry no meaning. In a small row the high column bits carry no meaning. The buffer count can be set to four or eight. Commands arrive already decoded into a kind code and the two halves of the bus word. Every result is registered, so it appears one clock after the command is sampled.

Top module: `nvrb_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `load_vld`, `rd_vld`, `rd_err` and `wr_err` are low. After reset no buffer counts as loaded, and the upper-bits latch of every buffer index holds zero.
- R2: `cmd_kind` codes are: 0 idle, 1 preactive, 2 activate, 3 read, 4 write, 5 refresh. Codes 6 and 7 are treated as idle. The buffer index is {BA2,BA1,BA0} = {`cmd_rise[7]`,`cmd_rise[8]`,`cmd_rise[9]`}. For a preactive, A29..A20 = `cmd_fall[9:0]` and A32..A30 = `cmd_rise[6:4]`.
- R3: An activate raises `load_vld` for exactly the following cycle. In that cycle `load_buf` holds the index and `load_addr` = {upper latch of that index (A32..A20), `cmd_rise[6:2]` (A19..A15), `cmd_fall[9:0]` (A14..A5), five zero bits (A4..A0)}. The result is masked as R6 describes. At most one of `load_vld`, `rd_vld` and `wr_err` is high in any cycle.
- R4: Each buffer index keeps its own upper-bits latch. An activate uses the value from the last preactive to that same index. Preactives to other indices do not change it.
- R5: The same array address may be loaded into several buffers. A buffer keeps the last address loaded into it.
- R6: The row size is 2^(5+`cfg_row_sel`) bytes, which spans 32 to 4096. On an activate, address bits below that power of two are forced to zero. The value sampled with the command applies.
- R7: A read raises `rd_vld` for the following cycle. `rd_buf` holds the index and `rd_row` holds the address last loaded into that buffer. `rd_byte` = {`cmd_fall[9:1]` (C11..C3), `cmd_rise[6:5]` (C2..C1), 0 (C0)}, with bits at or above 5+`cfg_row_sel` forced to zero.
- R8: With `cfg_eight_bufs` low, BA2 is ignored and treated as 0 for preactive, activate and read. Only buffers 0..3 are used.
- R9: A read of a buffer that has not been loaded since reset sets `rd_err` together with `rd_vld`, and `rd_row` reads zero.
- R10: A write command raises `wr_err` for the following cycle. It changes no buffer.
- R11: Refresh and idle codes produce no strobe and change no latch or buffer. A preactive produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_kind | input | 3 | Decoded command kind (R2 codes) |
| cmd_rise | input | 8 | Rising-half bus bits CA9..CA2, indexed [9:2] |
| cmd_fall | input | 10 | Falling-half bus bits CA9..CA0 |
| cfg_row_sel | input | 3 | Row size select, size = 32 << value |
| cfg_eight_bufs | input | 1 | 1: eight buffers, 0: four buffers |
| load_vld | output | 1 | Load request strobe |
| load_buf | output | 3 | Buffer to load |
| load_addr | output | 33 | Assembled array address A32..A0 |
| rd_vld | output | 1 | Read result strobe |
| rd_buf | output | 3 | Buffer read |
| rd_row | output | 33 | Array address held by that buffer |
| rd_byte | output | 12 | Byte offset within the buffer |
| rd_err | output | 1 | Read of a never-loaded buffer |
| wr_err | output | 1 | Unsupported write to a row buffer |

## Verification
The hardest case to reach is an activate whose upper bits came from a preactive several commands earlier to the same index. The preactives sent to other indices in between must have left that latch alone. The random phase confines buffer indices to a small set and mixes preactives, activates and reads heavily, so these interleavings occur often. Directed steps cover four-buffer aliasing, the 32-byte and 4096-byte row extremes, and a read from an empty buffer.

// File: rtl/nvrb_pkg.sv
`timescale 1ns/1ps
package nvrb_pkg;
    localparam int ADDR_W   = 33;
    localparam int COL_W    = 12;
    localparam int BA_W     = 3;
    localparam int NBUF     = 8;
    localparam int HI_W     = 13;
    localparam int LO_W     = 15;
    localparam int MIN_LOG2 = 5;
    localparam int SEL_W    = 3;
    localparam int CA_W     = 10;

    typedef enum logic [2:0] {
        K_IDLE    = 3'd0,
        K_PREACT  = 3'd1,
        K_ACT     = 3'd2,
        K_READ    = 3'd3,
        K_WRITE   = 3'd4,
        K_REFRESH = 3'd5
    } kind_e;

    typedef struct packed {
        logic [BA_W-1:0]  idx;
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
        logic [COL_W-1:0] col;
    } fields_t;

    // Bits kept in an assembled row address for a given size select.
    function automatic logic [ADDR_W-1:0] row_keep(input logic [SEL_W-1:0] sel);
        logic [ADDR_W-1:0] low;
        low = (ADDR_W'(1) << (MIN_LOG2 + int'(sel))) - ADDR_W'(1);
        return ~low;
    endfunction

    // Bits kept in a byte offset for a given size select.
    function automatic logic [COL_W-1:0] col_keep(input logic [SEL_W-1:0] sel);
        logic [COL_W:0] span;
        span = ((COL_W+1)'(1) << (MIN_LOG2 + int'(sel))) - (COL_W+1)'(1);
        return span[COL_W-1:0];
    endfunction
endpackage

// File: rtl/nvrb_cmd_split.sv
`timescale 1ns/1ps
module nvrb_cmd_split
    import nvrb_pkg::*;
#(
    parameter int FALL_W = CA_W
) (
    input  logic [9:2]        rise,
    input  logic [FALL_W-1:0] fall,
    input  logic              eight_bufs,
    output fields_t           fld
);
    always_comb begin
        fld.idx = {rise[7] & eight_bufs, rise[8], rise[9]};
        fld.hi  = {rise[6:4], fall};
        fld.lo  = {rise[6:2], fall};
        fld.col = {fall[9:1], rise[6:5], 1'b0};
    end
endmodule

// File: rtl/nvrb_buf_table.sv
`timescale 1ns/1ps
module nvrb_buf_table
    import nvrb_pkg::*;
#(
    parameter int N_ENT = NBUF,
    parameter int IDX_W = BA_W,
    parameter int UP_W  = HI_W,
    parameter int ROW_W = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hi_we,
    input  logic             row_we,
    input  logic [IDX_W-1:0] idx,
    input  logic [UP_W-1:0]  hi_wdata,
    input  logic [ROW_W-1:0] row_wdata,
    output logic [UP_W-1:0]  hi_rdata,
    output logic [ROW_W-1:0] row_rdata,
    output logic             row_valid
);
    logic [UP_W-1:0]  hi_q  [N_ENT];
    logic [ROW_W-1:0] row_q [N_ENT];
    logic [N_ENT-1:0] vld_q;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q[g]  <= '0;
                row_q[g] <= '0;
                vld_q[g] <= 1'b0;
            end else if (int'(idx) == g) begin
                if (hi_we)
                    hi_q[g] <= hi_wdata;
                if (row_we) begin
                    row_q[g] <= row_wdata;
                    vld_q[g] <= 1'b1;
                end
            end
        end
    end

    assign hi_rdata  = hi_q[idx];
    assign row_rdata = row_q[idx];
    assign row_valid = vld_q[idx];
endmodule

// File: rtl/nvrb_top.sv
`timescale 1ns/1ps
module nvrb_top
    import nvrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_kind,
    input  logic [9:2]        cmd_rise,
    input  logic [CA_W-1:0]   cmd_fall,
    input  logic [SEL_W-1:0]  cfg_row_sel,
    input  logic              cfg_eight_bufs,
    output logic              load_vld,
    output logic [BA_W-1:0]   load_buf,
    output logic [ADDR_W-1:0] load_addr,
    output logic              rd_vld,
    output logic [BA_W-1:0]   rd_buf,
    output logic [ADDR_W-1:0] rd_row,
    output logic [COL_W-1:0]  rd_byte,
    output logic              rd_err,
    output logic              wr_err
);
    fields_t           fld;
    logic [HI_W-1:0]   hi_rd;
    logic [ADDR_W-1:0] row_rd;
    logic              row_ok;
    logic [ADDR_W-1:0] act_addr;
    logic              is_pre, is_act, is_rd, is_wr;

    always_comb begin
        is_pre = (cmd_kind == K_PREACT);
        is_act = (cmd_kind == K_ACT);
        is_rd  = (cmd_kind == K_READ);
        is_wr  = (cmd_kind == K_WRITE);
    end

    nvrb_cmd_split #(.FALL_W(CA_W)) u_split (
        .rise       (cmd_rise),
        .fall       (cmd_fall),
        .eight_bufs (cfg_eight_bufs),
        .fld        (fld)
    );

    assign act_addr = {hi_rd, fld.lo, {MIN_LOG2{1'b0}}} & row_keep(cfg_row_sel);

    nvrb_buf_table #(
        .N_ENT (NBUF),
        .IDX_W (BA_W),
        .UP_W  (HI_W),
        .ROW_W (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .hi_we     (is_pre),
        .row_we    (is_act),
        .idx       (fld.idx),
        .hi_wdata  (fld.hi),
        .row_wdata (act_addr),
        .hi_rdata  (hi_rd),
        .row_rdata (row_rd),
        .row_valid (row_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_vld  <= 1'b0;
            load_buf  <= '0;
            load_addr <= '0;
            rd_vld    <= 1'b0;
            rd_buf    <= '0;
            rd_row    <= '0;
            rd_byte   <= '0;
            rd_err    <= 1'b0;
            wr_err    <= 1'b0;
        end else begin
            load_vld <= is_act;
            rd_vld   <= is_rd;
            rd_err   <= is_rd & ~row_ok;
            wr_err   <= is_wr;
            if (is_act) begin
                load_buf  <= fld.idx;
                load_addr <= act_addr;
            end
            if (is_rd) begin
                rd_buf  <= fld.idx;
                rd_row  <= row_ok ? row_rd : '0;
                rd_byte <= fld.col & col_keep(cfg_row_sel);
            end
        end
    end
endmodule

// File: rtl/nvrb_chk.sv
`timescale 1ns/1ps
module nvrb_chk
    import nvrb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd_kind,
    input logic [9:2]        cmd_rise,
    input logic [SEL_W-1:0]  cfg_row_sel,
    input logic              cfg_eight_bufs,
    input logic              load_vld,
    input logic [BA_W-1:0]   load_buf,
    input logic [ADDR_W-1:0] load_addr,
    input logic              rd_vld,
    input logic [BA_W-1:0]   rd_buf,
    input logic [ADDR_W-1:0] rd_row,
    input logic [COL_W-1:0]  rd_byte,
    input logic              rd_err,
    input logic              wr_err
);
    a_r10_write_flag: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd4) |=> wr_err);

    a_r11_quiet_cmds: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd0 || cmd_kind == 3'd1 || cmd_kind >= 3'd5)
        |=> !(load_vld || rd_vld || wr_err || rd_err));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_vld, rd_vld, wr_err}));

    a_r3_load_index: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd2) |=> (load_vld &&
            load_buf[1:0] == {$past(cmd_rise[8]), $past(cmd_rise[9])}));

    a_r6_row_low_zero: assert property (@(posedge clk) disable iff (rst)
        load_vld |-> (((load_addr >> (MIN_LOG2 + int'($past(cfg_row_sel))))
                       << (MIN_LOG2 + int'($past(cfg_row_sel)))) == load_addr));

    a_r7_col_high_zero: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> ((rd_byte >> (MIN_LOG2 + int'($past(cfg_row_sel)))) == '0)
                   && (rd_byte[0] == 1'b0));

    a_r8_four_bufs: assert property (@(posedge clk) disable iff (rst)
        (!cfg_eight_bufs && (cmd_kind == 3'd2 || cmd_kind == 3'd3))
        |=> !(load_vld && load_buf[2]) && !(rd_vld && rd_buf[2]));

    a_r9_err_row_zero: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_vld && rd_row == '0));
endmodule

bind nvrb_top nvrb_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_kind       (cmd_kind),
    .cmd_rise       (cmd_rise),
    .cfg_row_sel    (cfg_row_sel),
    .cfg_eight_bufs (cfg_eight_bufs),
    .load_vld       (load_vld),
    .load_buf       (load_buf),
    .load_addr      (load_addr),
    .rd_vld         (rd_vld),
    .rd_buf         (rd_buf),
    .rd_row         (rd_row),
    .rd_byte        (rd_byte),
    .rd_err         (rd_err),
    .wr_err         (wr_err)
);

// File: tb/tb_nvrb_top.sv
`timescale 1ns/1ps
module tb_nvrb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_kind = 3'd0;
    logic [9:2]  cmd_rise = '0;
    logic [9:0]  cmd_fall = '0;
    logic [2:0]  cfg_row_sel = 3'd0;
    logic        cfg_eight_bufs = 1'b1;
    logic        load_vld, rd_vld, rd_err, wr_err;
    logic [2:0]  load_buf, rd_buf;
    logic [32:0] load_addr, rd_row;
    logic [11:0] rd_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [12:0] m_hi  [8];
    logic [32:0] m_row [8];
    bit          m_vld [8];

    always #2.5 clk = ~clk;

    nvrb_top dut (
        .clk(clk), .rst(rst), .cmd_kind(cmd_kind), .cmd_rise(cmd_rise),
        .cmd_fall(cmd_fall), .cfg_row_sel(cfg_row_sel),
        .cfg_eight_bufs(cfg_eight_bufs), .load_vld(load_vld),
        .load_buf(load_buf), .load_addr(load_addr), .rd_vld(rd_vld),
        .rd_buf(rd_buf), .rd_row(rd_row), .rd_byte(rd_byte),
        .rd_err(rd_err), .wr_err(wr_err)
    );

    function automatic logic [2:0] exp_idx(logic [9:2] r, bit eight);
        return {r[7] & eight, r[8], r[9]};
    endfunction

    function automatic logic [32:0] exp_lowmask(logic [2:0] sel);
        return (33'd1 << (5 + int'(sel))) - 33'd1;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one command; outputs are sampled just after the next rising edge.
    task automatic issue(string tag, logic [2:0] kind, logic [9:2] r, logic [9:0] f);
        logic [2:0]  ix;
        logic [32:0] ea;
        logic [11:0] eb;
        logic [3:0]  strobes;
        @(negedge clk);
        cmd_kind = kind; cmd_rise = r; cmd_fall = f;
        ix = exp_idx(r, cfg_eight_bufs);
        ea = {m_hi[ix], r[6:2], f, 5'b0} & ~exp_lowmask(cfg_row_sel);
        eb = {f[9:1], r[6:5], 1'b0} & exp_lowmask(cfg_row_sel)[11:0];
        strobes = {kind == 3'd2, kind == 3'd3, kind == 3'd3 && !m_vld[ix], kind == 3'd4};
        @(posedge clk); #1;
        check({tag, " strobes"}, 128'({load_vld, rd_vld, rd_err, wr_err}), 128'(strobes));
        if (kind == 3'd2)
            check({tag, " load"}, 128'({load_buf, load_addr}), 128'({ix, ea}));
        if (kind == 3'd3)
            check({tag, " read"}, 128'({rd_buf, rd_row, rd_byte}),
                  128'({ix, (m_vld[ix] ? m_row[ix] : 33'd0), eb}));
        if (kind == 3'd1) m_hi[ix] = {r[6:4], f};
        if (kind == 3'd2) begin m_row[ix] = ea; m_vld[ix] = 1'b1; end
        cmd_kind = 3'd0;
    endtask

    function automatic logic [9:2] rbits(logic [2:0] ba, logic [4:0] up);
        return {ba[0], ba[1], ba[2], up};
    endfunction

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin m_hi[i] = '0; m_row[i] = '0; m_vld[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset strobes", 128'({load_vld, rd_vld, rd_err, wr_err}), 128'(0));
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 first cycle", 128'({load_vld, rd_vld, rd_err, wr_err}), 128'(0));
        // R1/R9: empty buffer read
        issue("R9 empty read", 3'd3, rbits(3'd0, 5'h1f), 10'h3ff);
        // R2/R3: preactive + activate field positions, eight buffers, 32-byte rows
        issue("R2 preact", 3'd1, rbits(3'd5, 5'b10100), 10'h2a5);
        issue("R3 activate", 3'd2, rbits(3'd5, 5'b01011), 10'h15a);
        issue("R7 read loaded", 3'd3, rbits(3'd5, 5'b11000), 10'h001);
        // R4: index without preactive uses zero; other index unaffected
        issue("R4 act no preact", 3'd2, rbits(3'd2, 5'b11111), 10'h3ff);
        issue("R4 preact other", 3'd1, rbits(3'd3, 5'b11100), 10'h3ff);
        issue("R4 act kept", 3'd2, rbits(3'd5, 5'b00001), 10'h000);
        // R5: same address into two buffers
        issue("R5 preact b1", 3'd1, rbits(3'd1, 5'b01100), 10'h0f0);
        issue("R5 preact b6", 3'd1, rbits(3'd6, 5'b01100), 10'h0f0);
        issue("R5 load b1", 3'd2, rbits(3'd1, 5'b10101), 10'h155);
        issue("R5 load b6", 3'd2, rbits(3'd6, 5'b10101), 10'h155);
        issue("R5 read b1", 3'd3, rbits(3'd1, 5'b00000), 10'h000);
        issue("R5 read b6", 3'd3, rbits(3'd6, 5'b00000), 10'h000);
        // R6/R7: largest row
        cfg_row_sel = 3'd7;
        issue("R6 big row load", 3'd2, rbits(3'd1, 5'b11111), 10'h3ff);
        issue("R7 big row read", 3'd3, rbits(3'd1, 5'b11111), 10'h3ff);
        cfg_row_sel = 3'd2;
        issue("R7 mid row read", 3'd3, rbits(3'd1, 5'b11111), 10'h3ff);
        // R8: four buffers, BA2 ignored
        cfg_eight_bufs = 1'b0;
        issue("R8 preact alias", 3'd1, rbits(3'd6, 5'b11100), 10'h123);
        issue("R8 act alias", 3'd2, rbits(3'd6, 5'b00000), 10'h3c3);
        issue("R8 read alias", 3'd3, rbits(3'd2, 5'b00000), 10'h000);
        // R10, R11
        issue("R10 write", 3'd4, rbits(3'd1, 5'b11111), 10'h3ff);
        issue("R11 refresh", 3'd5, rbits(3'd1, 5'b11111), 10'h3ff);
        issue("R11 code6", 3'd6, rbits(3'd1, 5'b11111), 10'h3ff);
        issue("R11 code7", 3'd7, rbits(3'd1, 5'b11111), 10'h3ff);
        issue("R11 read after", 3'd3, rbits(3'd1, 5'b00000), 10'h000);
        issue("R11 act after", 3'd2, rbits(3'd1, 5'b00000), 10'h000);
        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [2:0] k;
            int p;
            p = $urandom_range(0, 99);
            k = (p < 30) ? 3'd1 : (p < 60) ? 3'd2 : (p < 88) ? 3'd3 :
                3'($urandom_range(4, 7));
            if ($urandom_range(0, 19) == 0) begin
                cfg_row_sel = 3'($urandom_range(0, 7));
                cfg_eight_bufs = 1'($urandom_range(0, 1));
            end
            issue("R3 R4 R6 R7 random", k,
                  rbits(3'($urandom_range(0, 7) & 3'b101), 5'($urandom)),
                  10'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule